// File: doc/BRIEF.md
# Peripheral Access Arbiter with Core Ownership

This block guards one peripheral's register file that four bus masters share: two processor cores, a control-law accelerator and a DMA engine. A configuration register picks which of the two cores owns the peripheral. A separate two-bit permission field for each master decides whether that master may read and write, may only read, or may not touch the peripheral. The core that is not the owner is always shut out, whatever its field holds. The accelerator and the DMA engine always count as being on the owner's side, and their own fields still apply.

In any clock cycle the block grants at most one pending request. Write requests are considered before read requests. Within each of those two groups the DMA engine comes first, then the accelerator, then core 1, then core 2. The granted request then goes through the ownership and permission check. If it passes, it is forwarded to a synchronous register-file port that has one cycle of read latency. If it fails, the register file is not touched. One cycle after the grant, a shared response channel reports the ID of the granted master, the read data and an error flag. Masters that lose arbitration see a stall and hold their request until they are granted.

Configuration writes can happen at run time. A new setting applies to every request granted from the following cycle on.

Top module: `periph_access_arb`

## Requirements
- R1: After reset, core 1 (ID 0) is the owner, core 1's field is full access (2'b11), and the fields of core 2 (ID 1), the accelerator (ID 2) and the DMA engine (ID 3) are no access (2'b00).
- R2: A request from the core that is not the owner does not reach the register file, returns zero read data and sets the error flag, even if its field is 2'b11. Owner bit 0 selects core 1 and owner bit 1 selects core 2.
- R3: In cfg_access, the field of master i sits in bits [2i+1:2i]. 2'b11 allows reads and writes. 2'b01 allows reads only. 2'b00 and 2'b10 allow nothing.
- R4: A configuration written with cfg_we in cycle t governs requests granted from cycle t+1 on. A request granted in cycle t itself still uses the earlier setting.
- R5: Among competing requests of the same kind, the grant order is DMA, then accelerator, then core 1, then core 2.
- R6: If any pending request is a write, a write is granted ahead of every pending read.
- R7: At most one request is granted per cycle. Every other requesting master sees m_stall high, and the arbiter grants it in a later cycle if it holds its request.
- R8: A granted request that fails its check leaves rf_en low. In the next cycle it produces a single-cycle response with rsp_err high, the master's ID and rsp_rdata equal to zero.
- R9: A request granted in cycle t produces rsp_valid with its ID in cycle t+1. A permitted read returns the register-file word at its address. A permitted write stores its data.
- R10: Several masters may hold full access at once, and each of them can complete writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load a new owner and permission setting |
| cfg_owner | input | 1 | New owner: 0 selects core 1, 1 selects core 2 |
| cfg_access | input | 8 | New permission fields, 2 bits per master ID |
| m_req | input | 4 | Request per master (bit = ID) |
| m_we | input | 4 | Write flag per master |
| m_addr | input | 4*AW | Address per master, ID i at [i*AW +: AW] |
| m_wdata | input | 4*DW | Write data per master, ID i at [i*DW +: DW] |
| m_stall | output | 4 | Request pending but not granted this cycle |
| rf_en | output | 1 | Register-file access strobe |
| rf_we | output | 1 | Register-file write |
| rf_addr | output | AW | Register-file address |
| rf_wdata | output | DW | Register-file write data |
| rf_rdata | input | DW | Register-file read data, one cycle after rf_en |
| rsp_valid | output | 1 | Response for the previous cycle's grant |
| rsp_id | output | 2 | Master ID of that grant |
| rsp_err | output | 1 | Access was refused |
| rsp_rdata | output | DW | Read data, or zero |

## Verification
The bench makes reads and writes collide, so a design that ranked by master order alone, or by request kind alone, would show the wrong master unstalled. It sets a full-access field for the non-owner core and checks that the core is still refused. It tries a write with a read-only field and an access with the reserved 2'b10 field, so an encoding decoded as a single bit would be exposed. A refused write is followed by a read-back from the same address, which shows whether the refused write leaked into storage. A configuration update arriving in the same cycle as a request checks that the new setting is not applied one cycle early. Four masters held stalled together must drain in the documented order.

// File: rtl/pa_pkg.sv
package pa_pkg;
  localparam int NUM_M = 4;
  localparam int IDW   = 2;

  typedef enum logic [IDW-1:0] {
    M_CPU1 = 2'd0,
    M_CPU2 = 2'd1,
    M_ACC  = 2'd2,
    M_DMA  = 2'd3
  } master_e;

  localparam logic [1:0] PERM_FULL = 2'b11;
  localparam logic [1:0] PERM_RO   = 2'b01;
  localparam logic [1:0] PERM_NONE = 2'b00;

  typedef struct packed {
    logic           valid;
    logic           err;
    logic           rd;
    logic [IDW-1:0] id;
  } rsp_t;
endpackage

// File: rtl/pa_cfg.sv
module pa_cfg
  import pa_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               owner_in,
  input  logic [2*NUM_M-1:0] perm_in,
  output logic               owner_q,
  output logic [2*NUM_M-1:0] perm_q
);
  logic               owner_d;
  logic [2*NUM_M-1:0] perm_d;
  logic [2*NUM_M-1:0] perm_rst;

  always_comb begin
    perm_rst = '0;
    perm_rst[2*M_CPU1 +: 2] = PERM_FULL;
  end

  always_comb begin
    owner_d = owner_q;
    perm_d  = perm_q;
    if (wr_en) begin
      owner_d = owner_in;
      perm_d  = perm_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= 1'b0;
      perm_q  <= perm_rst;
    end else begin
      owner_q <= owner_d;
      perm_q  <= perm_d;
    end
  end
endmodule

// File: rtl/pa_perm.sv
module pa_perm
  import pa_pkg::*;
(
  input  logic               owner,
  input  logic [2*NUM_M-1:0] perm,
  input  logic [NUM_M-1:0]   is_wr,
  output logic [NUM_M-1:0]   allow
);
  for (genvar i = 0; i < NUM_M; i++) begin : g_m
    logic       on_side;
    logic [1:0] fld;
    logic       ok_wr;
    logic       ok_rd;

    if (i == int'(M_CPU1)) begin : g_c1
      assign on_side = (owner == 1'b0);
    end else if (i == int'(M_CPU2)) begin : g_c2
      assign on_side = (owner == 1'b1);
    end else begin : g_shared
      assign on_side = 1'b1;
    end

    assign fld      = perm[2*i +: 2];
    assign ok_wr    = (fld == PERM_FULL);
    assign ok_rd    = (fld == PERM_FULL) || (fld == PERM_RO);
    assign allow[i] = on_side && (is_wr[i] ? ok_wr : ok_rd);
  end
endmodule

// File: rtl/pa_arb.sv
module pa_arb
  import pa_pkg::*;
(
  input  logic [NUM_M-1:0] req,
  input  logic [NUM_M-1:0] we,
  output logic [NUM_M-1:0] gnt,
  output logic [IDW-1:0]   gnt_id,
  output logic             gnt_vld
);
  localparam logic [IDW-1:0] ORDER [NUM_M] = '{2'd3, 2'd2, 2'd0, 2'd1};

  logic [NUM_M-1:0] wr_pend;
  logic [NUM_M-1:0] rd_pend;
  logic [NUM_M-1:0] pool;

  assign wr_pend = req & we;
  assign rd_pend = req & ~we;
  assign pool    = (|wr_pend) ? wr_pend : rd_pend;

  always_comb begin
    gnt_id  = '0;
    gnt_vld = |pool;
    for (int r = NUM_M - 1; r >= 0; r--) begin
      if (pool[ORDER[r]]) gnt_id = ORDER[r];
    end
    gnt = '0;
    if (gnt_vld) gnt[gnt_id] = 1'b1;
  end
endmodule

// File: rtl/periph_access_arb.sv
module periph_access_arb
  import pa_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic                cfg_owner,
  input  logic [2*NUM_M-1:0]  cfg_access,
  input  logic [NUM_M-1:0]    m_req,
  input  logic [NUM_M-1:0]    m_we,
  input  logic [NUM_M*AW-1:0] m_addr,
  input  logic [NUM_M*DW-1:0] m_wdata,
  output logic [NUM_M-1:0]    m_stall,
  output logic                rf_en,
  output logic                rf_we,
  output logic [AW-1:0]       rf_addr,
  output logic [DW-1:0]       rf_wdata,
  input  logic [DW-1:0]       rf_rdata,
  output logic                rsp_valid,
  output logic [IDW-1:0]      rsp_id,
  output logic                rsp_err,
  output logic [DW-1:0]       rsp_rdata
);
  logic [1:0]         rst_pipe;
  logic               rst_int_n;
  logic               own_q;
  logic [2*NUM_M-1:0] perm_q;
  logic [NUM_M-1:0]   allow;
  logic [NUM_M-1:0]   gnt;
  logic [IDW-1:0]     gnt_id;
  logic               gnt_vld;
  logic               gnt_ok;
  rsp_t               rsp_d;
  rsp_t               rsp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  pa_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (cfg_we),
    .owner_in (cfg_owner),
    .perm_in  (cfg_access),
    .owner_q  (own_q),
    .perm_q   (perm_q)
  );

  pa_perm u_perm (
    .owner (own_q),
    .perm  (perm_q),
    .is_wr (m_we),
    .allow (allow)
  );

  pa_arb u_arb (
    .req     (m_req),
    .we      (m_we),
    .gnt     (gnt),
    .gnt_id  (gnt_id),
    .gnt_vld (gnt_vld)
  );

  assign m_stall  = m_req & ~gnt;
  assign gnt_ok   = gnt_vld && allow[gnt_id];
  assign rf_en    = gnt_ok;
  assign rf_we    = gnt_ok && m_we[gnt_id];
  assign rf_addr  = m_addr[gnt_id*AW +: AW];
  assign rf_wdata = m_wdata[gnt_id*DW +: DW];

  always_comb begin
    rsp_d.valid = gnt_vld;
    rsp_d.err   = gnt_vld && !allow[gnt_id];
    rsp_d.rd    = gnt_ok && !m_we[gnt_id];
    rsp_d.id    = gnt_id;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rsp_q <= '0;
    else            rsp_q <= rsp_d;
  end

  assign rsp_valid = rsp_q.valid;
  assign rsp_id    = rsp_q.id;
  assign rsp_err   = rsp_q.err;
  assign rsp_rdata = rsp_q.rd ? rf_rdata : '0;
endmodule

// File: rtl/pa_chk.sv
module pa_chk
  import pa_pkg::*;
#(
  parameter int DW = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NUM_M-1:0] m_req,
  input logic [NUM_M-1:0] m_we,
  input logic [NUM_M-1:0] m_stall,
  input logic             rf_en,
  input logic             rsp_valid,
  input logic             rsp_err,
  input logic [DW-1:0]    rsp_rdata
);
  // R7
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(m_req & ~m_stall) <= 1);

  // R7
  rf_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_en |-> (|(m_req & ~m_stall)));

  // R6
  write_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(m_req & m_we)) |-> (|(m_req & m_we & ~m_stall)));

  // R5
  dma_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req[M_DMA] && (m_we[M_DMA] || !(|(m_req & m_we)))) |-> !m_stall[M_DMA]);

  // R9
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(m_req & ~m_stall)) |=> rsp_valid);

  // R8
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && rsp_rdata == '0));
endmodule

bind periph_access_arb pa_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .m_req     (m_req),
  .m_we      (m_we),
  .m_stall   (m_stall),
  .rf_en     (rf_en),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .rsp_rdata (rsp_rdata)
);

// File: tb/sim_periph_access_arb.sv
`timescale 1ns/1ps
module sim_periph_access_arb;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int NV = 19;

  logic          clk;
  logic          rst_n;
  logic          cfg_we;
  logic          cfg_owner;
  logic [7:0]    cfg_access;
  logic [3:0]    m_req;
  logic [3:0]    m_we;
  logic [4*AW-1:0] m_addr;
  logic [4*DW-1:0] m_wdata;
  logic [3:0]    m_stall;
  logic          rf_en;
  logic          rf_we;
  logic [AW-1:0] rf_addr;
  logic [DW-1:0] rf_wdata;
  logic [DW-1:0] rf_rdata;
  logic          rsp_valid;
  logic [1:0]    rsp_id;
  logic          rsp_err;
  logic [DW-1:0] rsp_rdata;

  logic [DW-1:0] mem    [16];
  logic [DW-1:0] shadow [16];
  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // fields: owner, access, req, we, stall, valid, id, err
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 8'hF3, 4'b1111, 4'b0101, 4'b1011, 1'b1, 2'd2, 1'b0},
    {1'b0, 8'hF3, 4'b0001, 4'b0001, 4'b0000, 1'b1, 2'd0, 1'b0},
    {1'b0, 8'hF3, 4'b1001, 4'b0000, 4'b0001, 1'b1, 2'd3, 1'b0},
    {1'b0, 8'hF3, 4'b1001, 4'b0001, 4'b1000, 1'b1, 2'd0, 1'b0},
    {1'b0, 8'hF3, 4'b1100, 4'b1100, 4'b0100, 1'b1, 2'd3, 1'b0},
    {1'b0, 8'hFF, 4'b0010, 4'b0010, 4'b0000, 1'b1, 2'd1, 1'b1},
    {1'b1, 8'hFF, 4'b0010, 4'b0010, 4'b0000, 1'b1, 2'd1, 1'b0},
    {1'b1, 8'hFF, 4'b0001, 4'b0000, 4'b0000, 1'b1, 2'd0, 1'b1},
    {1'b1, 8'h4F, 4'b1000, 4'b1000, 4'b0000, 1'b1, 2'd3, 1'b1},
    {1'b1, 8'h4F, 4'b1000, 4'b0000, 4'b0000, 1'b1, 2'd3, 1'b0},
    {1'b1, 8'h2F, 4'b0100, 4'b0000, 4'b0000, 1'b1, 2'd2, 1'b1},
    {1'b1, 8'h2F, 4'b1000, 4'b0000, 4'b0000, 1'b1, 2'd3, 1'b1},
    {1'b1, 8'h0C, 4'b0010, 4'b0000, 4'b0000, 1'b1, 2'd1, 1'b0},
    {1'b1, 8'h0C, 4'b0000, 4'b0000, 4'b0000, 1'b0, 2'd0, 1'b0},
    {1'b0, 8'hFF, 4'b0011, 4'b0011, 4'b0010, 1'b1, 2'd0, 1'b0},
    {1'b0, 8'hFF, 4'b0010, 4'b0010, 4'b0000, 1'b1, 2'd1, 1'b1},
    {1'b1, 8'hFF, 4'b0010, 4'b0000, 4'b0000, 1'b1, 2'd1, 1'b0},
    {1'b1, 8'h1F, 4'b0100, 4'b0100, 4'b0000, 1'b1, 2'd2, 1'b1},
    {1'b1, 8'h1F, 4'b0100, 4'b0000, 4'b0000, 1'b1, 2'd2, 1'b0}
  };

  periph_access_arb #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_owner(cfg_owner),
    .cfg_access(cfg_access), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_stall(m_stall), .rf_en(rf_en), .rf_we(rf_we),
    .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
    .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (rf_en) begin
      if (rf_we) mem[rf_addr] <= rf_wdata;
      else       rf_rdata <= mem[rf_addr];
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // entered at a falling edge; leaves at the next falling edge with the response visible
  logic [3:0] stall_s;
  logic       rfen_s;
  task automatic req_cycle(input logic [3:0] rq, input logic [3:0] w);
    m_req = rq;
    m_we  = w;
    #3;
    stall_s = m_stall;
    rfen_s  = rf_en;
    @(negedge clk);
    m_req  = '0;
    m_we   = '0;
    cfg_we = 1'b0;
  endtask

  task automatic set_cfg(input logic own, input logic [7:0] acc);
    cfg_we     = 1'b1;
    cfg_owner  = own;
    cfg_access = acc;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [DW-1:0] wd(input int id, input int tag);
    return {4'hA, 2'b00, id[1:0], tag[7:0]};
  endfunction

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i]    = '0;
      shadow[i] = '0;
    end
    rf_rdata   = '0;
    rst_n      = 1'b0;
    cfg_we     = 1'b0;
    cfg_owner  = 1'b0;
    cfg_access = '0;
    m_req      = '0;
    m_we       = '0;
    m_addr     = {4'd7, 4'd6, 4'd5, 4'd4};
    m_wdata    = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state at the ports
    check(rsp_valid == 1'b0 && m_stall == 4'b0 && rf_en == 1'b0, "R1 idle after reset",
          {rsp_valid, m_stall, rf_en}, 0);
    for (int i = 0; i < 4; i++) m_wdata[i*DW +: DW] = wd(i, 200);
    req_cycle(4'b0001, 4'b0001);
    check(rfen_s == 1'b1, "R1 core1 write reaches file", rfen_s, 1);
    check(rsp_valid && rsp_id == 2'd0 && !rsp_err, "R1 core1 full after reset",
          {rsp_valid, rsp_id, rsp_err}, 3'b100);
    shadow[4] = wd(0, 200);
    for (int i = 1; i < 4; i++) begin
      req_cycle(4'(1 << i), 4'b0000);
      check(rsp_err && rsp_id == 2'(i) && rfen_s == 1'b0, "R1 other master no access",
            {rsp_err, rsp_id, rfen_s}, {1'b1, 2'(i), 1'b0});
    end

    // R4 update in the same cycle as a request: old setting applies
    cfg_we = 1'b1; cfg_owner = 1'b0; cfg_access = 8'hC3;
    req_cycle(4'b1000, 4'b0000);
    check(rsp_err == 1'b1, "R4 same-cycle request uses old setting", rsp_err, 1);
    req_cycle(4'b1000, 4'b0000);
    check(rsp_err == 1'b0 && rsp_valid, "R4 next request uses new setting", rsp_err, 0);

    // table of vectors
    for (int v = 0; v < NV; v++) begin
      logic       own;
      logic [7:0] acc;
      logic [3:0] rq, w, est;
      logic       evld, eerr;
      logic [1:0] eid;
      logic [DW-1:0] erd;
      {own, acc, rq, w, est, evld, eid, eerr} = VEC[v];
      set_cfg(own, acc);
      for (int i = 0; i < 4; i++) m_wdata[i*DW +: DW] = wd(i, v);
      req_cycle(rq, w);
      erd = '0;
      if (evld && !eerr && !w[eid]) erd = shadow[4 + eid];
      if (evld && !eerr && w[eid])  shadow[4 + eid] = wd(int'(eid), v);
      check(stall_s == est, "R5 R6 R7 stall pattern", stall_s, est);
      check(rfen_s == (evld && !eerr), "R2 R3 R8 file access", rfen_s, evld && !eerr);
      check(rsp_valid == evld, "R9 response valid", rsp_valid, evld);
      if (evld) begin
        check(rsp_id == eid, "R9 response id", rsp_id, eid);
        check(rsp_err == eerr, "R2 R3 R10 error flag", rsp_err, eerr);
        check(rsp_rdata == erd, "R8 R9 read data", rsp_rdata, erd);
      end
    end

    // R8 error pulse lasts one cycle
    set_cfg(1'b0, 8'h03);
    req_cycle(4'b0100, 4'b0000);
    check(rsp_err == 1'b1, "R8 error raised", rsp_err, 1);
    @(negedge clk);
    check(rsp_err == 1'b0 && rsp_valid == 1'b0, "R8 error is one cycle",
          {rsp_err, rsp_valid}, 0);

    // R7 held requests drain in priority order
    begin
      logic [3:0] held;
      logic [1:0] exp_order [4];
      exp_order = '{2'd3, 2'd2, 2'd0, 2'd1};
      set_cfg(1'b0, 8'hFF);
      held = 4'b1111;
      for (int s = 0; s < 4; s++) begin
        logic [3:0] gone;
        m_req = held;
        m_we  = '0;
        #3;
        gone = held & ~m_stall;
        check(gone == 4'(1 << exp_order[s]), "R7 held request order", gone,
              4'(1 << exp_order[s]));
        @(negedge clk);
        held = held & ~gone;
      end
      m_req = '0;
      @(negedge clk);
    end

    finish_run();
  end
endmodule